// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is an operating-system timer. A single 32-bit up-counter advances by one on every clock cycle in which the tick strobe is high. Four 32-bit compare values are held beside it. A channel reaches its compare value when the counter takes that value by counting, not by being loaded. If that channel is enabled, the channel latches a sticky status flag, and the flag drives the channel's own interrupt line. Channel 3 can also serve as a watchdog. When it is armed and channel 3 reaches its compare value, the block emits a single reset-request pulse and disarms itself.

Software reaches every register through a simple synchronous bus with byte offsets. A write takes effect on the clock edge where the write enable is high. Reads are combinational: they reflect the current address and the current state, so a read of the counter returns the live count. The tick strobe comes from whatever clock divider the chip provides; a typical rate is a few MHz.

Top module: `ostimer_top`

## Requirements
- R1: After a synchronous reset, every register reads zero, all four interrupt lines are low, the reset request is low and the watchdog is disarmed.
- R2: In each cycle with `tick_en` high and no counter write, the counter advances by one, modulo 2^32.
- R3: A write to offset 0x10 loads the counter on that edge and beats a simultaneous tick; counting then resumes from the loaded value, and a read of 0x10 returns the live count.
- R4: Channel i (compare value at offset 4*i) hits when a tick moves the counter onto its compare value. With enable bit i set, status bit i is set on that edge and `irq[i]` goes high. With enable bit i clear, a hit changes neither the status nor the line.
- R5: The enable register at offset 0x1C keeps bits 11:0 of a write and reads back those 12 bits. Bits 3:0 enable channels 3..0; bits 11:4 are stored but have no effect.
- R6: The status register at offset 0x14 shows the channel flags in bits 3:0. A write clears each flag whose bit is written as 1, and the matching `irq` line drops. A hit in the same cycle as the clear takes priority.
- R7: Bit 0 at offset 0x18 arms the watchdog. When it is armed and channel 3 hits, `wdog_rst_req` is high for exactly the one cycle after that edge, and the arm bit clears on the same edge. No further pulse follows until software writes bit 0 again. A write to 0x18 in the hit cycle takes precedence. The pulse does not depend on enable bit 3.
- R8: Compare values are written at offsets 0x00, 0x04, 0x08 and 0x0C and read back unchanged. Loading the counter directly onto a compare value causes no hit.
- R9: Reads of any other offset, including unaligned ones, return zero, and writes to them change nothing.
- R10: A compare value of zero hits when the counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count strobe, one step per high cycle |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | NUM_CH (4) | Per-channel interrupt lines, equal to the status flags |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Every internal register shows at the ports within one cycle. A corrupted count or compare value either moves a hit by at least one tick or appears directly on a read. A stuck or wrongly set status flag is visible on `irq` in the cycle after the bad edge. A wrong arm bit produces a missing, extra or repeated watchdog pulse on the next channel-3 hit, and a read of 0x18 also exposes it immediately. The bench's reference model predicts the read data, the interrupt lines and the reset request on every clock. Because of that, a divergence is reported in the cycle it first becomes observable, not later, at the end of a directed sequence.

// File: rtl/ostimer_pkg.sv
// Package: register offsets shared by the timer, its checker and its bench.
// Assumes byte addressing with 4-byte registers; only aligned offsets decode.
package ostimer_pkg;
    localparam int unsigned OFS_MATCH0 = 'h00;  // first compare value
    localparam int unsigned OFS_STRIDE = 4;     // spacing of compare values
    localparam int unsigned OFS_COUNT  = 'h10;  // live counter
    localparam int unsigned OFS_STATUS = 'h14;  // sticky flags, write 1 to clear
    localparam int unsigned OFS_WDOG   = 'h18;  // watchdog arm bit 0
    localparam int unsigned OFS_IEN    = 'h1C;  // channel enables
endpackage

// File: rtl/ostimer_counter.sv
// Free-running up-counter.
// Loads from the bus with priority over the tick strobe, wraps modulo 2^W.
// Also presents the incremented value and whether a step happens, for the compare logic.
module ostimer_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_inc,
    output logic         step
);
    assign cnt_inc = cnt_q + W'(1);
    assign step    = tick_en && !load;

    // Counter register: reset, load or step.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (tick_en) cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/ostimer_match_ch.sv
// One compare channel: holds a compare value and flags a hit.
// A hit means the counter is about to step onto the compare value.
// Assumes step and cnt_inc come from ostimer_counter.
module ostimer_match_ch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt_inc,
    output logic [W-1:0] match_q,
    output logic         hit
);
    assign hit = step && (cnt_inc == match_q);

    // Compare value register, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)  match_q <= '0;
        else if (wr) match_q <= wdata;
    end
endmodule

// File: rtl/ostimer_irq_ctrl.sv
// Interrupt enable, sticky status and watchdog arm/pulse logic.
// Assumes hit is a one-cycle strobe per channel.
// Within a cycle, a set beats a clear, and a software arm write beats the self-clear.
module ostimer_irq_ctrl #(
    parameter int NUM_CH  = 4,
    parameter int IEN_W   = 12,
    parameter int WDOG_CH = NUM_CH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              ien_wr,
    input  logic [IEN_W-1:0]  ien_wdata,
    input  logic              stat_wr,
    input  logic [NUM_CH-1:0] stat_wdata,
    input  logic              arm_wr,
    input  logic              arm_wdata,
    output logic [IEN_W-1:0]  ien_q,
    output logic [NUM_CH-1:0] stat_q,
    output logic              arm_q,
    output logic              wdog_req
);
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] set_mask;
    logic              fire;

    assign clr_mask = stat_wr ? stat_wdata : '0;
    assign set_mask = hit & ien_q[NUM_CH-1:0];
    assign fire     = hit[WDOG_CH] && arm_q;

    // Enable register: keeps all IEN_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    // Sticky status: clear written ones, then set enabled hits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_mask;
    end

    // Watchdog arm bit: set or cleared by software, self-clears when it fires.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= 1'b0;
        else if (arm_wr) arm_q <= arm_wdata;
        else if (fire)   arm_q <= 1'b0;
    end

    // Reset request: one registered cycle per firing.
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_req <= 1'b0;
        else        wdog_req <= fire;
    end
endmodule

// File: rtl/ostimer_top.sv
// Four-channel match timer with a watchdog on the last channel.
// Decodes a simple synchronous register bus, instantiates the counter,
// one compare channel per NUM_CH, and the interrupt/watchdog controller.
// Assumes NUM_CH <= 4 so compare offsets stay below the counter offset.
// Reads are combinational.
module ostimer_top
    import ostimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4,
    parameter int IEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic              wdog_rst_req
);
    localparam int WDOG_CH = NUM_CH - 1;

    logic              sel_cnt, sel_stat, sel_wdog, sel_ien;
    logic [NUM_CH-1:0] sel_match;
    logic [DATA_W-1:0] cnt_q, cnt_inc;
    logic              step;
    logic [DATA_W-1:0] match_q [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [IEN_W-1:0]  ien_q;
    logic [NUM_CH-1:0] stat_q;
    logic              arm_q;

    // Address decode for the fixed registers.
    assign sel_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STATUS));
    assign sel_wdog = (bus_addr == ADDR_W'(OFS_WDOG));
    assign sel_ien  = (bus_addr == ADDR_W'(OFS_IEN));

    ostimer_counter #(.W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (bus_we && sel_cnt),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_inc  (cnt_inc),
        .step     (step)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign sel_match[i] = (bus_addr == ADDR_W'(OFS_MATCH0 + OFS_STRIDE * i));

        ostimer_match_ch #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bus_we && sel_match[i]),
            .wdata   (bus_wdata),
            .step    (step),
            .cnt_inc (cnt_inc),
            .match_q (match_q[i]),
            .hit     (hit[i])
        );
    end

    ostimer_irq_ctrl #(
        .NUM_CH  (NUM_CH),
        .IEN_W   (IEN_W),
        .WDOG_CH (WDOG_CH)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .ien_wr     (bus_we && sel_ien),
        .ien_wdata  (bus_wdata[IEN_W-1:0]),
        .stat_wr    (bus_we && sel_stat),
        .stat_wdata (bus_wdata[NUM_CH-1:0]),
        .arm_wr     (bus_we && sel_wdog),
        .arm_wdata  (bus_wdata[0]),
        .ien_q      (ien_q),
        .stat_q     (stat_q),
        .arm_q      (arm_q),
        .wdog_req   (wdog_rst_req)
    );

    assign irq = stat_q;

    // Read multiplexer: zero for any offset that decodes to nothing.
    always_comb begin
        bus_rdata = '0;
        if (sel_cnt)  bus_rdata = cnt_q;
        if (sel_stat) bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, stat_q};
        if (sel_wdog) bus_rdata = {{(DATA_W-1){1'b0}}, arm_q};
        if (sel_ien)  bus_rdata = {{(DATA_W-IEN_W){1'b0}}, ien_q};
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_match[i]) bus_rdata = match_q[i];
        end
    end
endmodule

// File: rtl/ostimer_chk.sv
// Checker for ostimer_top: temporal properties over ports and internal state.
// Attached by the bind statement at the end of this file.
module ostimer_chk
    import ostimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] irq,
    input logic              wdog_rst_req,
    input logic [DATA_W-1:0] cnt_q,
    input logic [NUM_CH-1:0] ien_lo,
    input logic              arm_q,
    input logic [NUM_CH-1:0] hit
);
    localparam int WDOG_CH = NUM_CH - 1;

    logic ld_cnt, stat_wr, arm_wr;
    assign ld_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    assign arm_wr  = bus_we && (bus_addr == ADDR_W'(OFS_WDOG));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !ld_cnt) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));  // R2
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt |=> (cnt_q == $past(bus_wdata)));  // R3

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(hit[i]) && $past(ien_lo[i])));  // R4
        AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && bus_wdata[i] && !(hit[i] && ien_lo[i])) |=> !irq[i]);  // R6
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req |=> !wdog_rst_req);  // R7
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst_req) |-> $past(hit[WDOG_CH]));  // R7
    AST_REQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst_req && !$past(arm_wr)) |-> !arm_q);  // R7
endmodule

bind ostimer_top ostimer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .irq          (irq),
    .wdog_rst_req (wdog_rst_req),
    .cnt_q        (cnt_q),
    .ien_lo       (ien_q[NUM_CH-1:0]),
    .arm_q        (arm_q),
    .hit          (hit)
);

// File: tb/test_ostimer_top.sv
// Bench for ostimer_top.
// A behavioural reference model is compared on every clock; directed
// sequences add checks against hand-computed values.
// Inputs change 2 ns after a rising edge; outputs are sampled on the falling edge.
module test_ostimer_top;
    localparam int DW = 32, AW = 8, NCH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic          rst_n = 1'b0, tick_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] irq;
    logic          wdog_rst_req;

    int total = 0, bad = 0, req_seen = 0;
    bit model_ok = 1'b0;

    ostimer_top i_ostimer_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    // Reference model state.
    logic [31:0] m_cnt, m_match [4];
    logic [11:0] m_ien;
    logic [3:0]  m_stat;
    logic        m_arm, m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ien = 0; m_stat = 0; m_arm = 0; m_req = 0;
            foreach (m_match[k]) m_match[k] = 0;
            model_ok = 1'b1;
        end else begin
            logic wc, stp;
            logic [3:0] h, clr;
            wc  = bus_we && bus_addr == 8'h10;
            stp = tick_en && !wc;
            for (int k = 0; k < 4; k++) h[k] = stp && (m_cnt + 32'd1 == m_match[k]);
            clr = (bus_we && bus_addr == 8'h14) ? bus_wdata[3:0] : 4'b0;
            m_req  = h[3] && m_arm;
            m_stat = (m_stat & ~clr) | (h & m_ien[3:0]);
            if (bus_we && bus_addr == 8'h18) m_arm = bus_wdata[0];
            else if (m_req) m_arm = 1'b0;
            if (bus_we && bus_addr == 8'h1C) m_ien = bus_wdata[11:0];
            for (int k = 0; k < 4; k++)
                if (bus_we && bus_addr == 8'(4 * k)) m_match[k] = bus_wdata;
            if (wc) m_cnt = bus_wdata;
            else if (tick_en) m_cnt = m_cnt + 32'd1;
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a)
            8'h00: return m_match[0];
            8'h04: return m_match[1];
            8'h08: return m_match[2];
            8'h0C: return m_match[3];
            8'h10: return m_cnt;
            8'h14: return {28'b0, m_stat};
            8'h18: return {31'b0, m_arm};
            8'h1C: return {20'b0, m_ien};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08, 8'h0C: return "R8";
            8'h10: return "R3";
            8'h14: return "R6";
            8'h18: return "R7";
            8'h1C: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (model_ok && rst_n) begin
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R4", {28'b0, irq}, {28'b0, m_stat});
            chk("R7", {31'b0, wdog_rst_req}, {31'b0, m_req});
            if (wdog_rst_req) req_seen++;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic run(int n);
        tick_en = 1'b1;
        repeat (n) cyc();
        tick_en = 1'b0;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state.
        foreach (exp_rd_list[k]) rd_chk(exp_rd_list[k], 32'h0, "R1");
        chk("R1", {27'b0, irq, wdog_rst_req}, 32'h0);
        // R9: unmapped offsets.
        wr(8'h24, 32'hDEAD_BEEF);
        wr(8'h06, 32'h1234_5678);
        rd_chk(8'h24, 32'h0, "R9");
        rd_chk(8'h06, 32'h0, "R9");
        rd_chk(8'h04, 32'h0, "R9");
        // R5: enable keeps 12 bits.
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk(8'h1C, 32'h0000_0FFF, "R5");
        wr(8'h1C, 32'h0000_0005);
        rd_chk(8'h1C, 32'h5, "R5");
        // R8: compare values.
        wr(8'h00, 32'd10); wr(8'h04, 32'd20); wr(8'h08, 32'd15); wr(8'h0C, 32'd30);
        rd_chk(8'h00, 32'd10, "R8"); rd_chk(8'h04, 32'd20, "R8");
        rd_chk(8'h08, 32'd15, "R8"); rd_chk(8'h0C, 32'd30, "R8");
        // R2 and R4: count and hit on channels 0 and 2; channel 1 disabled.
        wr(8'h10, 32'd0);
        run(12);
        rd_chk(8'h10, 32'd12, "R2");
        rd_chk(8'h14, 32'h1, "R4");
        run(10);
        rd_chk(8'h10, 32'd22, "R2");
        rd_chk(8'h14, 32'h5, "R4");
        chk("R4", {28'b0, irq}, 32'h5);
        // R6: write one to clear.
        wr(8'h14, 32'h3);
        rd_chk(8'h14, 32'h4, "R6");
        chk("R6", {28'b0, irq}, 32'h4);
        wr(8'h14, 32'hF);
        rd_chk(8'h14, 32'h0, "R6");
        // R7: watchdog pulse with enable bit 3 clear.
        wr(8'h18, 32'h1);
        rd_chk(8'h18, 32'h1, "R7");
        wr(8'h10, 32'd28);
        tick_en = 1'b1;
        cyc();
        cyc();
        @(negedge clk); chk("R7", {31'b0, wdog_rst_req}, 32'h1);
        cyc();
        @(negedge clk); chk("R7", {31'b0, wdog_rst_req}, 32'h0);
        tick_en = 1'b0;
        rd_chk(8'h18, 32'h0, "R7");
        rd_chk(8'h14, 32'h0, "R4");
        wr(8'h10, 32'd28);
        run(4);
        chk("R7", req_seen, 32'd1);
        // R8: loading onto a compare value gives no hit.
        wr(8'h18, 32'h1);
        wr(8'h10, 32'd30);
        rd_chk(8'h18, 32'h1, "R8");
        chk("R8", req_seen, 32'd1);
        wr(8'h18, 32'h0);
        // R3: load beats a tick.
        tick_en = 1'b1;
        wr(8'h10, 32'd100);
        tick_en = 1'b0;
        rd_chk(8'h10, 32'd100, "R3");
        // R10: wrap onto compare value zero.
        wr(8'h00, 32'd0); wr(8'h1C, 32'h1);
        wr(8'h10, 32'hFFFF_FFFE);
        run(3);
        rd_chk(8'h10, 32'd1, "R10");
        rd_chk(8'h14, 32'h1, "R10");
        // R6: a hit in the clear cycle wins.
        wr(8'h00, 32'd5); wr(8'h10, 32'd4);
        tick_en = 1'b1;
        wr(8'h14, 32'h1);
        tick_en = 1'b0;
        rd_chk(8'h14, 32'h1, "R6");
        // Mixed traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            pick = $urandom % 10;
            bus_addr  = (pick < 8) ? exp_rd_list[pick] : 8'($urandom);
            bus_we    = ($urandom % 4) == 0;
            bus_wdata = (($urandom % 3) == 0) ? $urandom : ($urandom % 48);
            tick_en   = ($urandom % 3) != 0;
            cyc();
        end
        bus_we = 1'b0; tick_en = 1'b0;
        cyc();
        finish_up();
    end

    logic [7:0] exp_rd_list [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C};
endmodule